// File: doc/BRIEF.md
# Speculative Folded Branch History

This block keeps the speculative global branch history for a multi-stage branch predictor. The history is a shift register with the newest outcome in bit 0. Alongside it the block keeps a set of folded copies. Each copy compresses a window of the newest history bits down to the index width of one predictor table, so a table index can be formed from the folded value with a single XOR against the fetch address.

In every cycle the block takes at most one update from five possible sources, chosen by a fixed priority. Each source shifts zero, one or two outcome bits into a base history. The folded copies are not rebuilt from the whole register. They are advanced incrementally, using only the incoming bit and the bit that leaves each window.

Each pipeline stage carries the history that was in force when its bundle entered. A later stage is allowed to correct an earlier stage only when its own prediction is actually different. A redirect from outside the predictor loads a complete history. That history may have the resolved outcome of the redirecting branch appended to it.

Top module: `spec_fold_hist`

## Requirements
- R1: After reset, `ghist_o` and every folded copy in `fold_o` read zero.
- R2: After every cycle, folded copy c equals the XOR, over every j below its history length L_c, of history bit j placed at position j mod W_c. W_c is the smaller of L_c and the table index width. The copies are packed into `fold_o` starting at bit 0, in configuration order: (8,8), (13,11), (32,11), (119,11), (4,4), (16,8).
- R3: An s1 result with `s1_slot`=0 shifts in its outcome only, so bit 0 becomes `s1_taken`. An s1 result with `s1_slot`=1 shifts in a 0 and then its outcome, so bit 1 becomes 0 and bit 0 becomes `s1_taken`. The base for the shift is the history the bundle captured when it entered s1.
- R4: A stage result with its branch flag low sets the history equal to that stage's carried base, with no bits shifted in.
- R5: An s2 result takes effect only when it differs from the s1 result the same bundle had, which is captured when `s2_fire` is high. Otherwise it is ignored. Two results are equal when both have no branch, or when both have a branch with the same slot and the same outcome.
- R6: An s3 result takes effect only when it differs from the s2 result captured on `s3_fire`. That includes the case where s3 agrees with the s1 result after s2 overrode it.
- R7: When several sources are active in one cycle, the highest one wins: redirect, then s3, then s2, then s1.
- R8: A redirect loads `redir_ghist` and `redir_fold` as they are. When `redir_add` is 1, `redir_taken` is first shifted into bit 0.
- R9: With no source active, the history and the folded copies hold their values.
- R10: On `s1_fire`, the entering bundle captures the history written in that same cycle. On `s2_fire` and `s3_fire`, the previous stage's carried history moves forward.
- R11: Every update appears on `ghist_o` and `fold_o` at the first clock edge after the source is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s1_fire | input | 1 | A bundle enters stage 1 |
| s2_fire | input | 1 | The stage-1 bundle moves to stage 2 |
| s3_fire | input | 1 | The stage-2 bundle moves to stage 3 |
| s1_valid | input | 1 | Stage-1 result present |
| s1_has_br | input | 1 | Stage-1 bundle holds a conditional branch |
| s1_slot | input | 1 | Slot of the stage-1 deciding branch |
| s1_taken | input | 1 | Stage-1 predicted outcome |
| s2_valid | input | 1 | Stage-2 result present |
| s2_has_br | input | 1 | Stage-2 bundle holds a conditional branch |
| s2_slot | input | 1 | Slot of the stage-2 deciding branch |
| s2_taken | input | 1 | Stage-2 predicted outcome |
| s3_valid | input | 1 | Stage-3 result present |
| s3_has_br | input | 1 | Stage-3 bundle holds a conditional branch |
| s3_slot | input | 1 | Slot of the stage-3 deciding branch |
| s3_taken | input | 1 | Stage-3 predicted outcome |
| redir_valid | input | 1 | External redirect |
| redir_add | input | 1 | Append the resolved outcome to the returned history |
| redir_taken | input | 1 | Resolved outcome of the redirecting branch |
| redir_ghist | input | GH_LEN | Returned global history |
| redir_fold | input | SFH_FOLD_TOT | Returned folded copies |
| ghist_o | output | GH_LEN | Speculative global history, newest bit 0 |
| fold_o | output | SFH_FOLD_TOT | Packed folded copies |

## Verification
Every source is presented between clock edges and is due on the outputs at the very next rising edge. The bench therefore drives inputs at a falling edge and compares against its reference model at the following falling edge, one cycle later. A stage capture also takes one edge, so a bundle entering s1 sees a value that can be checked on the next cycle's update. Hand-computed history values back the model for the slot, suppression and redirect cases. The folded outputs are re-folded from the model history after every cycle.

// File: rtl/sfh_pkg.sv
package sfh_pkg;

    localparam int SFH_NFOLD = 6;
    localparam int SFH_HLEN [SFH_NFOLD] = '{8, 13, 32, 119, 4, 16};
    localparam int SFH_IDXW [SFH_NFOLD] = '{8, 11, 11, 11, 8, 8};

    function automatic int sfh_fold_w(int c);
        return (SFH_IDXW[c] < SFH_HLEN[c]) ? SFH_IDXW[c] : SFH_HLEN[c];
    endfunction

    function automatic int sfh_fold_off(int c);
        int s;
        s = 0;
        for (int k = 0; k < c; k++) s += sfh_fold_w(k);
        return s;
    endfunction

    localparam int SFH_FOLD_TOT = sfh_fold_off(SFH_NFOLD);

    typedef struct packed {
        logic has_br;
        logic slot;
        logic taken;
    } br_res_t;

    typedef enum logic [2:0] {
        SRC_HOLD,
        SRC_S1,
        SRC_S2,
        SRC_S3,
        SRC_REDIR
    } hist_src_e;

    // Two results are equal when neither has a branch, or all fields match.
    function automatic logic res_differs(br_res_t a, br_res_t b);
        if (!a.has_br && !b.has_br) return 1'b0;
        return (a != b);
    endfunction

    function automatic logic [1:0] res_nbits(br_res_t r);
        if (!r.has_br) return 2'd0;
        return r.slot ? 2'd2 : 2'd1;
    endfunction

endpackage

// File: rtl/sfh_src_select.sv
module sfh_src_select
    import sfh_pkg::*;
#(
    parameter int GHW = 128,
    parameter int FTW = 53
) (
    input  logic           redir_valid,
    input  logic           redir_add,
    input  logic           redir_taken,
    input  logic [GHW-1:0] redir_gh,
    input  logic [FTW-1:0] redir_fd,
    input  logic           s3_valid,
    input  br_res_t        s3_res,
    input  br_res_t        s3_prev,
    input  logic [GHW-1:0] s3_gh,
    input  logic [FTW-1:0] s3_fd,
    input  logic           s2_valid,
    input  br_res_t        s2_res,
    input  br_res_t        s2_prev,
    input  logic [GHW-1:0] s2_gh,
    input  logic [FTW-1:0] s2_fd,
    input  logic           s1_valid,
    input  br_res_t        s1_res,
    input  logic [GHW-1:0] s1_gh,
    input  logic [FTW-1:0] s1_fd,
    input  logic [GHW-1:0] cur_gh,
    input  logic [FTW-1:0] cur_fd,
    output hist_src_e      src,
    output logic [GHW-1:0] base_gh,
    output logic [FTW-1:0] base_fd,
    output logic [1:0]     nbits,
    output logic           new_bit
);

    always_comb begin
        src     = SRC_HOLD;
        base_gh = cur_gh;
        base_fd = cur_fd;
        nbits   = 2'd0;
        new_bit = 1'b0;
        if (redir_valid) begin
            src     = SRC_REDIR;
            base_gh = redir_gh;
            base_fd = redir_fd;
            nbits   = {1'b0, redir_add};
            new_bit = redir_taken;
        end else if (s3_valid && res_differs(s3_res, s3_prev)) begin
            src     = SRC_S3;
            base_gh = s3_gh;
            base_fd = s3_fd;
            nbits   = res_nbits(s3_res);
            new_bit = s3_res.taken;
        end else if (s2_valid && res_differs(s2_res, s2_prev)) begin
            src     = SRC_S2;
            base_gh = s2_gh;
            base_fd = s2_fd;
            nbits   = res_nbits(s2_res);
            new_bit = s2_res.taken;
        end else if (s1_valid) begin
            src     = SRC_S1;
            base_gh = s1_gh;
            base_fd = s1_fd;
            nbits   = res_nbits(s1_res);
            new_bit = s1_res.taken;
        end
    end

endmodule

// File: rtl/sfh_fold_lane.sv
module sfh_fold_lane #(
    parameter int HLEN = 8,
    parameter int W    = 8
) (
    input  logic [W-1:0] base_fold,
    input  logic         out_a,
    input  logic         out_b,
    input  logic [1:0]   nbits,
    input  logic         new_bit,
    output logic [W-1:0] nxt_fold
);

    // Position where the bit leaving the window lands after the rotate.
    localparam int P = HLEN % W;

    function automatic logic [W-1:0] rotl(logic [W-1:0] f);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[i] = f[(i + W - 1) % W];
        return r;
    endfunction

    logic [W-1:0] step1_d;
    logic [W-1:0] step2_d;

    always_comb begin
        step1_d    = rotl(base_fold);
        step1_d[P] = step1_d[P] ^ out_a;
        step2_d    = rotl(step1_d);
        step2_d[P] = step2_d[P] ^ out_b;
        unique case (nbits)
            2'd1: begin
                nxt_fold    = step1_d;
                nxt_fold[0] = step1_d[0] ^ new_bit;
            end
            2'd2: begin
                nxt_fold    = step2_d;
                nxt_fold[0] = step2_d[0] ^ new_bit;
            end
            default: nxt_fold = base_fold;
        endcase
    end

endmodule

// File: rtl/spec_fold_hist.sv
module spec_fold_hist
    import sfh_pkg::*;
#(
    parameter int GH_LEN = 128
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    s1_fire,
    input  logic                    s2_fire,
    input  logic                    s3_fire,
    input  logic                    s1_valid,
    input  logic                    s1_has_br,
    input  logic                    s1_slot,
    input  logic                    s1_taken,
    input  logic                    s2_valid,
    input  logic                    s2_has_br,
    input  logic                    s2_slot,
    input  logic                    s2_taken,
    input  logic                    s3_valid,
    input  logic                    s3_has_br,
    input  logic                    s3_slot,
    input  logic                    s3_taken,
    input  logic                    redir_valid,
    input  logic                    redir_add,
    input  logic                    redir_taken,
    input  logic [GH_LEN-1:0]       redir_ghist,
    input  logic [SFH_FOLD_TOT-1:0] redir_fold,
    output logic [GH_LEN-1:0]       ghist_o,
    output logic [SFH_FOLD_TOT-1:0] fold_o
);

    localparam int FT = SFH_FOLD_TOT;

    typedef struct packed {
        logic [GH_LEN-1:0] gh;
        logic [FT-1:0]     fd;
        logic [GH_LEN-1:0] s1_gh;
        logic [FT-1:0]     s1_fd;
        logic [GH_LEN-1:0] s2_gh;
        logic [FT-1:0]     s2_fd;
        br_res_t           s2_prev;
        logic [GH_LEN-1:0] s3_gh;
        logic [FT-1:0]     s3_fd;
        br_res_t           s3_prev;
    } hist_state_t;

    hist_state_t st_d, st_q;

    br_res_t r1, r2, r3;
    assign r1 = '{has_br: s1_has_br, slot: s1_slot, taken: s1_taken};
    assign r2 = '{has_br: s2_has_br, slot: s2_slot, taken: s2_taken};
    assign r3 = '{has_br: s3_has_br, slot: s3_slot, taken: s3_taken};

    hist_src_e         sel_src;
    logic [GH_LEN-1:0] base_gh;
    logic [FT-1:0]     base_fd;
    logic [1:0]        sel_nbits;
    logic              sel_bit;
    logic [GH_LEN-1:0] nxt_gh;
    logic [FT-1:0]     nxt_fd;

    sfh_src_select #(.GHW(GH_LEN), .FTW(FT)) u_sel (
        .redir_valid (redir_valid),
        .redir_add   (redir_add),
        .redir_taken (redir_taken),
        .redir_gh    (redir_ghist),
        .redir_fd    (redir_fold),
        .s3_valid    (s3_valid),
        .s3_res      (r3),
        .s3_prev     (st_q.s3_prev),
        .s3_gh       (st_q.s3_gh),
        .s3_fd       (st_q.s3_fd),
        .s2_valid    (s2_valid),
        .s2_res      (r2),
        .s2_prev     (st_q.s2_prev),
        .s2_gh       (st_q.s2_gh),
        .s2_fd       (st_q.s2_fd),
        .s1_valid    (s1_valid),
        .s1_res      (r1),
        .s1_gh       (st_q.s1_gh),
        .s1_fd       (st_q.s1_fd),
        .cur_gh      (st_q.gh),
        .cur_fd      (st_q.fd),
        .src         (sel_src),
        .base_gh     (base_gh),
        .base_fd     (base_fd),
        .nbits       (sel_nbits),
        .new_bit     (sel_bit)
    );

    for (genvar c = 0; c < SFH_NFOLD; c++) begin : g_lane
        localparam int LW  = sfh_fold_w(c);
        localparam int OFF = sfh_fold_off(c);
        localparam int HL  = SFH_HLEN[c];
        sfh_fold_lane #(.HLEN(HL), .W(LW)) u_lane (
            .base_fold (base_fd[OFF +: LW]),
            .out_a     (base_gh[HL-1]),
            .out_b     (base_gh[HL-2]),
            .nbits     (sel_nbits),
            .new_bit   (sel_bit),
            .nxt_fold  (nxt_fd[OFF +: LW])
        );
    end

    always_comb begin
        unique case (sel_nbits)
            2'd1:    nxt_gh = {base_gh[GH_LEN-2:0], sel_bit};
            2'd2:    nxt_gh = {base_gh[GH_LEN-3:0], 1'b0, sel_bit};
            default: nxt_gh = base_gh;
        endcase
    end

    always_comb begin
        st_d    = st_q;
        st_d.gh = nxt_gh;
        st_d.fd = nxt_fd;
        if (s1_fire) begin
            st_d.s1_gh = nxt_gh;
            st_d.s1_fd = nxt_fd;
        end
        if (s2_fire) begin
            st_d.s2_gh   = st_q.s1_gh;
            st_d.s2_fd   = st_q.s1_fd;
            st_d.s2_prev = r1;
        end
        if (s3_fire) begin
            st_d.s3_gh   = st_q.s2_gh;
            st_d.s3_fd   = st_q.s2_fd;
            st_d.s3_prev = r2;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ghist_o = st_q.gh;
    assign fold_o  = st_q.fd;

    // Full re-fold of a history value, used only by the consistency check.
    function automatic logic [FT-1:0] refold_all(logic [GH_LEN-1:0] g);
        logic [FT-1:0] r;
        r = '0;
        for (int c = 0; c < SFH_NFOLD; c++)
            for (int j = 0; j < SFH_HLEN[c]; j++)
                r[sfh_fold_off(c) + (j % sfh_fold_w(c))] ^= g[j];
        return r;
    endfunction

    always @(posedge clk)
        if (rst_n) a_r2_fold_refold: assert (st_q.fd == refold_all(st_q.gh));

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!redir_valid && !s1_valid && !s2_valid && !s3_valid)
        |=> ($stable(ghist_o) && $stable(fold_o)));

    a_r8_redir_plain: assert property (@(posedge clk) disable iff (!rst_n)
        (redir_valid && !redir_add) |=> (ghist_o == $past(redir_ghist)));

    a_r8_redir_append: assert property (@(posedge clk) disable iff (!rst_n)
        (redir_valid && redir_add)
        |=> (ghist_o[0] == $past(redir_taken) &&
             ghist_o[GH_LEN-1:1] == $past(redir_ghist[GH_LEN-2:0])));

    a_r4_no_branch: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_src == SRC_S1 && !s1_has_br) |=> (ghist_o == $past(st_q.s1_gh)));

    a_r7_redir_wins: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> (sel_src == SRC_REDIR));

endmodule

// File: tb/spec_fold_hist_tb_top.sv
`timescale 1ns/1ps
module spec_fold_hist_tb_top;

    localparam int GHL = 128;
    localparam int FT  = 53;
    localparam int NF  = 6;
    localparam int HL [NF] = '{8, 13, 32, 119, 4, 16};
    localparam int WD [NF] = '{8, 11, 11, 11, 4, 8};

    logic clk = 1'b0;
    logic rst_n;
    logic s1_fire, s2_fire, s3_fire;
    logic s1_valid, s1_has_br, s1_slot, s1_taken;
    logic s2_valid, s2_has_br, s2_slot, s2_taken;
    logic s3_valid, s3_has_br, s3_slot, s3_taken;
    logic redir_valid, redir_add, redir_taken;
    logic [GHL-1:0] redir_ghist;
    logic [FT-1:0]  redir_fold;
    logic [GHL-1:0] ghist_o;
    logic [FT-1:0]  fold_o;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    logic [GHL-1:0] m_gh, m_g1, m_g2, m_g3;
    logic [2:0]     m_p2, m_p3;

    always #4 clk = ~clk;

    spec_fold_hist #(.GH_LEN(GHL)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .s1_fire(s1_fire), .s2_fire(s2_fire), .s3_fire(s3_fire),
        .s1_valid(s1_valid), .s1_has_br(s1_has_br), .s1_slot(s1_slot), .s1_taken(s1_taken),
        .s2_valid(s2_valid), .s2_has_br(s2_has_br), .s2_slot(s2_slot), .s2_taken(s2_taken),
        .s3_valid(s3_valid), .s3_has_br(s3_has_br), .s3_slot(s3_slot), .s3_taken(s3_taken),
        .redir_valid(redir_valid), .redir_add(redir_add), .redir_taken(redir_taken),
        .redir_ghist(redir_ghist), .redir_fold(redir_fold),
        .ghist_o(ghist_o), .fold_o(fold_o)
    );

    function automatic logic [FT-1:0] refold(logic [GHL-1:0] g);
        logic [FT-1:0] r;
        int off;
        r = '0;
        off = 0;
        for (int c = 0; c < NF; c++) begin
            for (int j = 0; j < HL[c]; j++) r[off + (j % WD[c])] ^= g[j];
            off += WD[c];
        end
        return r;
    endfunction

    function automatic logic differs(logic [2:0] a, logic [2:0] b);
        if (!a[2] && !b[2]) return 1'b0;
        return a != b;
    endfunction

    function automatic logic [GHL-1:0] shift_res(logic [GHL-1:0] g, logic [2:0] r);
        if (!r[2]) return g;
        if (r[1]) return {g[GHL-3:0], 1'b0, r[0]};
        return {g[GHL-2:0], r[0]};
    endfunction

    task automatic chk(string tag, logic [GHL-1:0] act, logic [GHL-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        s1_fire = 0; s2_fire = 0; s3_fire = 0;
        s1_valid = 0; s1_has_br = 0; s1_slot = 0; s1_taken = 0;
        s2_valid = 0; s2_has_br = 0; s2_slot = 0; s2_taken = 0;
        s3_valid = 0; s3_has_br = 0; s3_slot = 0; s3_taken = 0;
        redir_valid = 0; redir_add = 0; redir_taken = 0;
    endtask

    // One clock: model the update, then compare one edge later (R11, R2).
    task automatic step();
        logic [GHL-1:0] nx, g1n, g2n, g3n;
        logic [2:0] p2n, p3n, o1, o2, o3;
        o1 = {s1_has_br, s1_slot, s1_taken};
        o2 = {s2_has_br, s2_slot, s2_taken};
        o3 = {s3_has_br, s3_slot, s3_taken};
        if (redir_valid)                    nx = redir_add ? {redir_ghist[GHL-2:0], redir_taken} : redir_ghist;
        else if (s3_valid && differs(o3, m_p3)) nx = shift_res(m_g3, o3);
        else if (s2_valid && differs(o2, m_p2)) nx = shift_res(m_g2, o2);
        else if (s1_valid)                  nx = shift_res(m_g1, o1);
        else                                nx = m_gh;
        g1n = s1_fire ? nx : m_g1;
        g2n = s2_fire ? m_g1 : m_g2;
        p2n = s2_fire ? o1 : m_p2;
        g3n = s3_fire ? m_g2 : m_g3;
        p3n = s3_fire ? o2 : m_p3;
        @(posedge clk);
        m_gh = nx; m_g1 = g1n; m_g2 = g2n; m_g3 = g3n; m_p2 = p2n; m_p3 = p3n;
        @(negedge clk);
        chk("R11 history after update", ghist_o, m_gh);
        chk("R2 folded copies", {{(GHL-FT){1'b0}}, fold_o}, {{(GHL-FT){1'b0}}, refold(m_gh)});
        idle();
    endtask

    task automatic t_reset();
        idle();
        redir_ghist = '0; redir_fold = '0;
        rst_n = 0;
        m_gh = '0; m_g1 = '0; m_g2 = '0; m_g3 = '0; m_p2 = '0; m_p3 = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 history zero", ghist_o, '0);
        chk("R1 folds zero", {{(GHL-FT){1'b0}}, fold_o}, '0);
    endtask

    task automatic t_s1_slots();
        s1_fire = 1; step();
        s1_valid = 1; s1_has_br = 1; s1_slot = 0; s1_taken = 1; s1_fire = 1; step();
        chk("R3 slot0 taken", {120'b0, ghist_o[7:0]}, 128'h01);
        s1_valid = 1; s1_has_br = 1; s1_slot = 1; s1_taken = 1; s1_fire = 1; step();
        chk("R3 slot1 taken", {120'b0, ghist_o[7:0]}, 128'h05);
        chk("R10 s1 entry captured new value", {120'b0, ghist_o[7:0]}, {120'b0, m_g1[7:0]});
        s1_valid = 1; s1_has_br = 1; s1_slot = 1; s1_taken = 0; s1_fire = 1; step();
        chk("R3 slot1 not taken", {120'b0, ghist_o[7:0]}, 128'h14);
        s1_valid = 1; s1_has_br = 1; s1_slot = 0; s1_taken = 0; s1_fire = 1; step();
        chk("R3 slot0 not taken", {120'b0, ghist_o[7:0]}, 128'h28);
        s1_valid = 1; s1_has_br = 0; s1_slot = 1; s1_taken = 1; s1_fire = 1; step();
        chk("R4 no branch", {120'b0, ghist_o[7:0]}, 128'h28);
        step();
        chk("R9 hold", {120'b0, ghist_o[7:0]}, 128'h28);
    endtask

    task automatic t_stream();
        for (int i = 0; i < 160; i++) begin
            s1_fire = 1; s1_valid = 1; s1_has_br = (i % 7) != 3;
            s1_slot = (i % 3) == 0; s1_taken = ((i * 7) % 5) < 2;
            step();
        end
    endtask

    task automatic t_s2();
        logic [GHL-1:0] g;
        s1_fire = 1; step();
        g = ghist_o;
        s1_valid = 1; s1_has_br = 1; s1_taken = 1; s2_fire = 1; step();
        chk("R3 s1 applied", ghist_o, {g[GHL-2:0], 1'b1});
        s2_valid = 1; s2_has_br = 1; s2_taken = 1; step();
        chk("R5 equal s2 ignored", ghist_o, {g[GHL-2:0], 1'b1});
        s2_valid = 1; s2_has_br = 1; s2_taken = 0; step();
        chk("R5 differing s2 from carried base", ghist_o, {g[GHL-2:0], 1'b0});
    endtask

    task automatic t_s3();
        logic [GHL-1:0] g;
        s1_fire = 1; step();
        g = ghist_o;
        s1_valid = 1; s1_has_br = 1; s1_taken = 1; s2_fire = 1; step();
        s2_valid = 1; s2_has_br = 1; s2_taken = 0; s3_fire = 1; step();
        chk("R5 s2 override", ghist_o, {g[GHL-2:0], 1'b0});
        s3_valid = 1; s3_has_br = 1; s3_taken = 0; step();
        chk("R6 equal s3 ignored", ghist_o, {g[GHL-2:0], 1'b0});
        s3_valid = 1; s3_has_br = 1; s3_taken = 1;
        s2_valid = 1; s2_has_br = 1; s2_slot = 1; s2_taken = 1;
        s1_valid = 1; s1_has_br = 1; s1_slot = 1; s1_taken = 1;
        step();
        chk("R6 R7 s3 back to s1 view wins", ghist_o, {g[GHL-2:0], 1'b1});
    endtask

    task automatic t_redir();
        logic [GHL-1:0] p;
        p = {4{32'hA5C3_1E97}};
        redir_ghist = p; redir_fold = refold(p);
        redir_valid = 1; s1_valid = 1; s1_has_br = 1; s1_taken = 1;
        s3_valid = 1; s3_has_br = 1; s3_taken = 1;
        step();
        chk("R8 R7 plain redirect wins", ghist_o, p);
        redir_valid = 1; redir_add = 1; redir_taken = 1; s1_fire = 1; step();
        chk("R8 redirect appends taken", ghist_o, {p[GHL-2:0], 1'b1});
        s1_valid = 1; s1_has_br = 1; s1_slot = 0; s1_taken = 0; step();
        chk("R10 s1 base is redirected value", ghist_o, {p[GHL-3:0], 2'b10});
        redir_valid = 1; redir_add = 1; redir_taken = 0; step();
        chk("R8 redirect appends not taken", ghist_o, {p[GHL-2:0], 1'b0});
    endtask

    initial begin
        t_reset();
        t_s1_slots();
        t_stream();
        t_s2();
        t_s3();
        t_redir();
        t_stream();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

endmodule